// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous request port and an external asynchronous static RAM. The RAM has 17 address bits, an 8-bit data bus and four control pins: a low-active select, a high-active select, a low-active output strobe and a low-active write strobe. A client offers one word-wide read or write with a valid/ready handshake. The controller holds the address and the strobes for the required number of system clock cycles, then returns read data with a one-cycle valid pulse. Each minimum time is given in nanoseconds. It is rounded up to whole clock cycles from the clock period.

The memory data bus is split into an output word, a tristate enable and an input word, which the pad ring joins. The tristate enable is raised only while a write pulse is in progress and for one cycle after it. If a write directly follows a read, the controller first inserts a quiet interval. This gives the memory time to release the bus after the output strobe rises. When the port stays idle for a set number of cycles, the low-active select is released and the memory drops to standby. The first access after that starts with a wake interval of one read-cycle length.

States: `ST_IDLE` (ready, selected or in standby), `ST_WAKE` (recovery from standby), `ST_RD` (output strobe low), `ST_TURN` (bus release after a read), `ST_WR` (write strobe low, data driven), `ST_WREL` (write strobe high, data still driven), `ST_WREC` (remaining write-cycle time). Transitions:
- `ST_IDLE` to `ST_WAKE` on an accepted request while in standby.
- `ST_IDLE` or `ST_WAKE` (at its end) to `ST_RD` for a read.
- `ST_IDLE` or `ST_WAKE` to `ST_TURN` for a write whose previous operation was a read.
- `ST_IDLE` or `ST_WAKE` to `ST_WR` for any other write.
- `ST_TURN` to `ST_WR`.
- `ST_WR` to `ST_WREL`.
- `ST_WREL` to `ST_WREC` when the write cycle needs extra time, otherwise to `ST_IDLE`.
- `ST_WREC` to `ST_IDLE`.
- `ST_RD` to `ST_IDLE`, with read data captured.

Top module: `asram_ctrl`

## Requirements
- R1: During reset the low-active select is high, the high-active select is low, both strobes are high, the bus enable is off, and `req_ready` and `rd_valid` are low.
- R2: The output strobe or the write strobe is low only while `mem_sel_n` is 0 and `mem_sel` is 1. The two strobes are never low together.
- R3: `req_ready` is high only in the idle state after reset. A request is taken when `req_valid` and `req_ready` are both high, and only one operation runs at a time.
- R4: A read holds the output strobe low for exactly RC cycles, with a stable address equal to the requested one. The input word is captured at the end of that window and shown on `rd_data`, and `rd_valid` is high for exactly one cycle, RC+1 cycles after acceptance (without wake).
- R5: A write holds the write strobe low for exactly WE cycles with a stable address. The bus enable is high from the first strobe-low cycle through the first cycle after the strobe rises. `req_ready` returns WE+max(1,WC−WE)+1 cycles after acceptance.
- R6: The bus enable is never high while the output strobe is low, nor outside the window in R5.
- R7: A write whose previous operation was a read starts driving the bus TURN cycles later than an ordinary write, so the output strobe has been high for at least TURN cycles first.
- R8: After IDLE_LIMIT consecutive idle cycles with no request, `mem_sel_n` goes high while `mem_sel` stays high. It stays low after IDLE_LIMIT−1 cycles.
- R9: A request accepted in standby is preceded by RC wake cycles, with the memory selected and both strobes high. It then completes as in R4 or R5, delayed by RC cycles.
- R10: Each cycle count is the ceiling of its nanosecond value over the clock period. WE is the largest of the pulse width, address-to-end and data-setup counts. RC comes from the read cycle, WC from the write cycle and TURN from the output release time (at least 1). With a 10 ns clock and the defaults: RC=5, WE=4, WC=5, TURN=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` holds read result |
| rd_data | output | 8 | Read result |
| mem_addr | output | 17 | Memory address pins |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Tristate enable of the data pins |
| mem_dq_in | input | 8 | Data from the memory pins |
| mem_sel_n | output | 1 | Low-active chip select |
| mem_sel | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Low-active output strobe |
| mem_we_n | output | 1 | Low-active write strobe |

## Verification
The memory model returns a garbage byte until the output strobe has been held low for RC−1 full edges. A controller that samples even one cycle early therefore returns wrong data. The bench counts strobe lengths and compares the bus enable against the write strobe in every cycle. This catches a pulse that is one cycle short, or data released as the strobe rises. Each write that follows a read is timed from acceptance, so a controller without the turnaround state drives the bus two cycles early. Standby entry is probed one cycle before and at the limit, which exposes an off-by-one idle counter. Reads from standby check the added wake latency.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_RD,
        ST_TURN,
        ST_WR,
        ST_WREL,
        ST_WREC
    } asram_state_e;

    // Whole clock cycles covering a nanosecond interval (zero stays zero).
    function automatic int ns_to_cyc(int ns, int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_standby.sv
module asram_standby #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wake,
    output logic sleep
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          sleep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sleep_q <= 1'b0;
        end else begin
            if (wake) sleep_q <= 1'b0;
            if (!tick) begin
                cnt_q <= '0;
            end else if (!sleep_q) begin
                if (cnt_q == CW'(LIMIT - 1)) begin
                    sleep_q <= 1'b1;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign sleep = sleep_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 10,
    parameter int T_RC_NS    = 45,
    parameter int T_PWE_NS   = 35,
    parameter int T_AW_NS    = 35,
    parameter int T_SD_NS    = 20,
    parameter int T_WC_NS    = 45,
    parameter int T_HZOE_NS  = 15,
    parameter int IDLE_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    // Cycle counts derived from the speed grade and the clock period.
    localparam int RC_CYC   = imax(1, ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int WE_CYC   = imax(1, imax(ns_to_cyc(T_PWE_NS, CLK_NS),
                                           imax(ns_to_cyc(T_AW_NS, CLK_NS),
                                                ns_to_cyc(T_SD_NS, CLK_NS))));
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int HOLD_CYC = (WC_CYC > WE_CYC) ? (WC_CYC - WE_CYC) : 1;
    localparam int REC_CYC  = HOLD_CYC - 1;
    localparam int TURN_CYC = imax(1, ns_to_cyc(T_HZOE_NS, CLK_NS));
    localparam int MAX_CYC  = imax(imax(RC_CYC, WE_CYC), imax(HOLD_CYC, TURN_CYC));
    localparam int TMR_W    = $clog2(MAX_CYC + 1);

    asram_state_e state_q, state_d;
    asram_state_e disp_state;
    logic [TMR_W-1:0] disp_val;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_load;
    logic             tmr_done;
    logic             sleep;
    logic             run_q;
    logic             accept;
    logic             go_write;
    logic             op_write_q;
    logic             last_rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    assign accept = req_valid && req_ready;

    asram_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asram_standby #(.LIMIT(IDLE_LIMIT)) u_standby (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (run_q && (state_q == ST_IDLE) && !req_valid),
        .wake  (accept && sleep),
        .sleep (sleep)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, read capture and history flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            op_write_q <= 1'b0;
            last_rd_q  <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            run_q      <= 1'b1;
            rd_valid_q <= 1'b0;
            if (accept) begin
                op_write_q <= req_write;
                addr_q     <= req_addr;
                wdata_q    <= req_wdata;
            end
            if (state_q == ST_RD && tmr_done) begin
                rd_data_q  <= mem_dq_in;
                rd_valid_q <= 1'b1;
                last_rd_q  <= 1'b1;
            end else if (state_q == ST_WR || sleep) begin
                last_rd_q  <= 1'b0;
            end
        end
    end

    // Where a starting operation goes first
    always_comb begin
        go_write = (state_q == ST_IDLE) ? req_write : op_write_q;
        if (go_write && last_rd_q) begin
            disp_state = ST_TURN;
            disp_val   = TMR_W'(TURN_CYC - 1);
        end else if (go_write) begin
            disp_state = ST_WR;
            disp_val   = TMR_W'(WE_CYC - 1);
        end else begin
            disp_state = ST_RD;
            disp_val   = TMR_W'(RC_CYC - 1);
        end
    end

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (sleep) begin
                        state_d = ST_WAKE;
                        tmr_val = TMR_W'(RC_CYC - 1);
                    end else begin
                        state_d = disp_state;
                        tmr_val = disp_val;
                    end
                end
            end
            ST_WAKE: begin
                if (tmr_done) begin
                    state_d  = disp_state;
                    tmr_load = 1'b1;
                    tmr_val  = disp_val;
                end
            end
            ST_RD: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_TURN: begin
                if (tmr_done) begin
                    state_d  = ST_WR;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(WE_CYC - 1);
                end
            end
            ST_WR: begin
                if (tmr_done) state_d = ST_WREL;
            end
            ST_WREL: begin
                if (REC_CYC > 0) begin
                    state_d  = ST_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WREC: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin decode
    always_comb begin
        req_ready  = run_q && (state_q == ST_IDLE);
        mem_sel    = run_q;
        mem_sel_n  = !run_q || ((state_q == ST_IDLE) && sleep);
        mem_oe_n   = (state_q != ST_RD);
        mem_we_n   = (state_q != ST_WR);
        mem_dq_oe  = (state_q == ST_WR) || (state_q == ST_WREL);
        mem_dq_out = wdata_q;
        mem_addr   = addr_q;
        rd_valid   = rd_valid_q;
        rd_data    = rd_data_q;
    end

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    a_r2_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (!mem_sel_n && mem_sel));

    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    a_r6_no_drive_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r5_drive_past_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    a_r5_drive_covers_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    a_r5_addr_held_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    a_r4_addr_held_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    a_r3_ready_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
    localparam int CLKP  = 10;
    localparam int LIMIT = 8;

    function automatic int cyc(int ns);
        return (ns + CLKP - 1) / CLKP;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // R10: expected counts from the nanosecond grade
    localparam int RC   = cyc(45);
    localparam int WE   = mx(cyc(35), mx(cyc(35), cyc(20)));
    localparam int WC   = cyc(45);
    localparam int HOLD = (WC > WE) ? WC - WE : 1;
    localparam int TURN = mx(1, cyc(15));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n;

    always #(CLKP/2) clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Memory model: data appears only after a full access interval
    logic [7:0] mem [256];
    int         rd_age = 0;
    logic       msel;
    assign msel = !mem_sel_n && mem_sel;
    assign mem_dq_in = (msel && !mem_oe_n && mem_we_n && rd_age >= RC - 1)
                       ? mem[mem_addr[7:0]] : 8'hEE;

    always @(posedge clk) begin
        if (msel && !mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dq_out;
        if (msel && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
        else                               rd_age <= 0;
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit prev_read = 1'b0;
    logic [16:0] exp_addr = '0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pin monitors
    int  we_run = 0, oe_run = 0, oe_hi_age = 0;
    logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) we_run++;
            else if (!prev_we_n) begin
                chk(we_run == WE, "R5", "write strobe length (R10)", we_run, WE);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (!prev_oe_n) begin
                chk(oe_run == RC, "R4", "output strobe length (R10)", oe_run, RC);
                oe_run = 0;
            end
            if (mem_dq_oe != (!mem_we_n || !prev_we_n))
                chk(1'b0, "R6", "bus enable window", int'(mem_dq_oe), int'(!mem_we_n || !prev_we_n));
            if ((!mem_oe_n || !mem_we_n) && !(msel))
                chk(1'b0, "R2", "strobe without select", 0, 1);
            if ((!mem_we_n && prev_we_n) || (!mem_oe_n && prev_oe_n))
                chk(mem_addr == exp_addr, "R4", "address at strobe fall", int'(mem_addr), int'(exp_addr));
            if (req_ready && (!mem_oe_n || !mem_we_n))
                chk(1'b0, "R3", "ready while busy", 1, 0);
            if (mem_dq_oe && !prev_dq_oe)
                chk(oe_hi_age >= TURN, "R7", "output strobe high before drive", oe_hi_age, TURN);
            oe_hi_age = mem_oe_n ? oe_hi_age + 1 : 0;
            prev_we_n  = mem_we_n;
            prev_oe_n  = mem_oe_n;
            prev_dq_oe = mem_dq_oe;
        end
    end

    task automatic issue(bit wr, logic [16:0] a, logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic do_write(logic [16:0] a, logic [7:0] d, int pre);
        int n = 0;
        issue(1'b1, a, d);
        do begin @(negedge clk); n++; end while (!mem_dq_oe && n < 100);
        chk(n == pre + 1, "R5", "drive start latency (R7 R9)", n, pre + 1);
        while (!req_ready && n < 200) begin @(negedge clk); n++; end
        chk(n == pre + WE + HOLD + 1, "R5", "write cycle length", n, pre + WE + HOLD + 1);
        prev_read = 1'b0;
    endtask

    task automatic do_read(logic [16:0] a, logic [7:0] exp, int pre);
        int n = 0;
        issue(1'b0, a, 8'h00);
        do begin @(negedge clk); n++; end while (!rd_valid && n < 100);
        chk(n == pre + RC + 1, "R4", "read latency (R9)", n, pre + RC + 1);
        chk(rd_data == exp, "R4", "read data", int'(rd_data), int'(exp));
        @(negedge clk);
        chk(!rd_valid, "R4", "valid pulse width", int'(rd_valid), 0);
        prev_read = 1'b1;
    endtask

    function automatic logic [7:0] f1(int a); return 8'(a * 3 + 1); endfunction
    function automatic logic [7:0] f2(int a); return 8'(a) ^ 8'hC3; endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_sel_n == 1'b1, "R1", "sel_n in reset", int'(mem_sel_n), 1);
        chk(mem_sel == 1'b0, "R1", "sel in reset", int'(mem_sel), 0);
        chk(mem_oe_n && mem_we_n, "R1", "strobes in reset", int'({mem_oe_n, mem_we_n}), 3);
        chk(!mem_dq_oe && !req_ready && !rd_valid, "R1", "enable/ready/valid in reset",
            int'({mem_dq_oe, req_ready, rd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(req_ready, "R3", "ready after reset", int'(req_ready), 1);

        // Sweep: write all, read all, read-then-write turnaround
        for (int a = 0; a < 64; a++) do_write(17'(a), f1(a), prev_read ? TURN : 0);
        for (int a = 0; a < 64; a++) begin
            do_read(17'(a), f1(a), 0);
            if (a % 2 == 0) begin
                do_write(17'(a), f2(a), TURN);   // R7
                do_read(17'(a), f2(a), 0);
            end
        end
        // Address extremes
        do_write(17'h1FFFF, 8'h5A, TURN);
        do_read(17'h1FFFF, 8'h5A, 0);
        do_write(17'h10000, 8'hA5, TURN);
        do_read(17'h10000, 8'hA5, 0);
        do_write(17'h00001, 8'h3C, TURN);

        // R8: standby entry exactly at the limit (do_write returns in idle cycle 1)
        repeat (LIMIT - 1) @(negedge clk);
        chk(mem_sel_n == 1'b0, "R8", "selected one cycle before limit", int'(mem_sel_n), 0);
        @(negedge clk);
        chk(mem_sel_n == 1'b1, "R8", "standby at limit", int'(mem_sel_n), 1);
        chk(mem_sel == 1'b1, "R8", "high select kept", int'(mem_sel), 1);
        // R9: read from standby
        do_read(17'h00001, 8'h3C, RC);
        repeat (LIMIT + 2) @(negedge clk);
        chk(mem_sel_n == 1'b1, "R8", "standby again", int'(mem_sel_n), 1);
        do_write(17'h00002, 8'h77, RC);   // R9: write from standby
        do_read(17'h00002, 8'h77, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLKP * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule